// File: doc/BRIEF.md
# Predicated SIMD Immediate Shifter

This block shifts every lane of a 128-bit vector by one immediate amount. The vector is read as sixteen 8-bit lanes, eight 16-bit lanes or four 32-bit lanes. The shift can be left, logical right or arithmetic right. A right shift may use an amount equal to the full lane width, and that case has a defined result: zero for a logical shift, and the sign bit copied across the lane for an arithmetic shift.

An optional per-byte predicate controls which lanes take the shifted value. A lane that is not selected takes its value from a separate inactive vector. An immediate outside the legal range for the chosen operation and lane size raises an error flag. In that case the source vector goes to the output unchanged.

A start strobe launches one operation. The result, an error flag and a one-cycle valid pulse appear on the next clock edge.

Top module: `simd_imm_shifter`

## Requirements
- R1: `lane_sz_i` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes and 2 gives 32-bit lanes. Lane i occupies bits [i*W +: W]. Code 3 is reserved and is treated as an illegal operation (see R8).
- R2: With `dir_right_i`=0, every lane is shifted left by `imm_i` and zeros enter at the bottom. The legal immediates are 0 to W-1.
- R3: With `dir_right_i`=1, every lane is shifted right by `imm_i`, with legal immediates from 1 to W. `unsigned_i`=1 selects a logical shift, which fills with zeros. `unsigned_i`=0 selects an arithmetic shift, which fills with the lane's sign bit.
- R4: A logical right shift by exactly W produces zero in every lane.
- R5: An arithmetic right shift by exactly W gives the same result as a shift by W-1: each lane is filled with its own sign bit.
- R6: With `pred_en_i`=1, `pred_i` holds one bit per byte. A lane is active when the bit of its lowest byte is set: bit i for 8-bit lanes, bit 2i for 16-bit lanes and bit 4i for 32-bit lanes. Inactive lanes output the matching lane of `inact_i`. The other predicate bits have no effect.
- R7: With `pred_en_i`=0, every lane takes the shifted value whatever `pred_i` holds.
- R8: An illegal immediate, or lane code 3, sets `err_o`=1 and `res_o` equals `src_i`. For a legal operation `err_o`=0.
- R9: `res_o` and `err_o` are loaded on the clock edge that samples `start_i`=1, and `valid_o` is high for exactly that following cycle. While `start_i`=0, `res_o` and `err_o` hold their values.
- R10: A synchronous active-low reset clears `res_o`, `valid_o` and `err_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launches one operation |
| lane_sz_i | input | 2 | Lane width code (0: 8, 1: 16, 2: 32) |
| dir_right_i | input | 1 | 1 = right shift, 0 = left shift |
| unsigned_i | input | 1 | For right shifts: 1 = logical, 0 = arithmetic |
| imm_i | input | 6 | Shift amount |
| pred_en_i | input | 1 | Enables predicated merging |
| pred_i | input | 16 | Per-byte predicate |
| src_i | input | 128 | Source vector |
| inact_i | input | 128 | Vector supplying the inactive lanes |
| res_o | output | 128 | Registered result |
| valid_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Illegal immediate or lane code |

## Verification
The assertions assume that all inputs are stable and known whenever `start_i` is sampled high. They also assume that `start_i` is never asserted while reset is low. The bench drives every input on the falling clock edge and holds it there until after the rising edge that samples it. It releases reset before the first operation. The checker derives legality straight from the input ports, so the error and full-width properties also hold for stimulus that deliberately uses illegal immediates and the reserved lane code.

// File: rtl/shim_pkg.sv
// Shared constants and helpers for the immediate shifter.
// Assumes the vector width is a multiple of 32 bits.
package shim_pkg;
    localparam int VEC_W  = 128;
    localparam int MAX_LW = 32;
    localparam int IMM_W  = $clog2(MAX_LW + 1);
    localparam int NSIZE  = 3;

    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_RSV = 2'd3
    } lane_sz_e;
endpackage

// File: rtl/shim_lane_unit.sv
// Shifts one lane of width LW by an immediate.
// Assumes: a right shift amount equal to LW is legal; a logical shift then
// gives zero and an arithmetic shift is clamped to LW-1.
module shim_lane_unit #(
    parameter int LW = 8,
    parameter int AW = 6
) (
    input  logic [LW-1:0] din,
    input  logic [AW-1:0] amt,
    input  logic          right,
    input  logic          uns,
    output logic [LW-1:0] dout
);
    localparam logic [AW-1:0] LW_A  = AW'(LW);
    localparam logic [AW-1:0] LWM_A = AW'(LW - 1);

    logic [AW-1:0] asr_amt;

    // Clamp the arithmetic amount so a full-width shift replicates the sign.
    always_comb asr_amt = (amt >= LW_A) ? LWM_A : amt;

    // Pick the shift kind for this lane.
    always_comb begin
        if (!right)
            dout = din << amt;
        else if (uns)
            dout = (amt >= LW_A) ? '0 : (din >> amt);
        else
            dout = $signed(din) >>> asr_amt;
    end
endmodule

// File: rtl/shim_vec_shift.sv
// Builds lane shifters for all three lane widths and selects one result.
// Assumes VEC_W is a multiple of 32; an unknown size code passes src through.
module shim_vec_shift #(
    parameter int VEC_W = 128,
    parameter int AW    = 6
) (
    input  logic [VEC_W-1:0] src,
    input  logic [1:0]       sz,
    input  logic [AW-1:0]    amt,
    input  logic             right,
    input  logic             uns,
    output logic [VEC_W-1:0] dout
);
    logic [VEC_W-1:0] by_size [3];

    for (genvar g = 0; g < 3; g++) begin : g_size
        localparam int LW = 8 << g;
        localparam int NL = VEC_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            shim_lane_unit #(.LW(LW), .AW(AW)) u_lane (
                .din  (src[l*LW +: LW]),
                .amt  (amt),
                .right(right),
                .uns  (uns),
                .dout (by_size[g][l*LW +: LW])
            );
        end
    end

    // Select the vector computed for the requested lane width.
    always_comb begin
        case (sz)
            2'd0:    dout = by_size[0];
            2'd1:    dout = by_size[1];
            2'd2:    dout = by_size[2];
            default: dout = src;
        endcase
    end
endmodule

// File: rtl/shim_imm_check.sv
// Decides whether the immediate is legal for the operation and lane width.
// Left: 0..W-1. Right: 1..W. Lane code 3 is never legal.
module shim_imm_check #(
    parameter int AW = 6
) (
    input  logic [1:0]    sz,
    input  logic          right,
    input  logic [AW-1:0] amt,
    output logic          legal
);
    logic [AW-1:0] lw_a;

    // Lane width as an immediate-sized value.
    always_comb lw_a = AW'(8) << sz;

    // Range test for the selected direction.
    always_comb begin
        if (sz == 2'd3)
            legal = 1'b0;
        else if (right)
            legal = (amt != '0) && (amt <= lw_a);
        else
            legal = amt < lw_a;
    end
endmodule

// File: rtl/shim_pred_merge.sv
// Merges shifted bytes with inactive bytes under a per-byte predicate.
// A lane follows the predicate bit of its lowest byte; when disabled, all
// lanes are active.
module shim_pred_merge #(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0]   shifted,
    input  logic [VEC_W-1:0]   inact,
    input  logic [1:0]         sz,
    input  logic               pen,
    input  logic [VEC_W/8-1:0] pred,
    output logic [VEC_W-1:0]   dout
);
    localparam int NB = VEC_W / 8;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        localparam int B16 = b & ~1;
        localparam int B32 = b & ~3;
        logic act;

        // Predicate bit that governs this byte's lane.
        always_comb begin
            case (sz)
                2'd1:    act = pred[B16];
                2'd2:    act = pred[B32];
                default: act = pred[b];
            endcase
        end

        // Take the shifted byte when active or when predication is off.
        assign dout[b*8 +: 8] = (!pen || act) ? shifted[b*8 +: 8]
                                              : inact[b*8 +: 8];
    end
endmodule

// File: rtl/simd_imm_shifter.sv
// Predicated lane-wise immediate shifter with a registered output.
// Assumes inputs are stable when start_i is sampled; illegal operations
// pass src_i through and raise err_o.
module simd_imm_shifter #(
    parameter int VEC_W = shim_pkg::VEC_W,
    parameter int IMM_W = shim_pkg::IMM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [1:0]         lane_sz_i,
    input  logic               dir_right_i,
    input  logic               unsigned_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic               pred_en_i,
    input  logic [VEC_W/8-1:0] pred_i,
    input  logic [VEC_W-1:0]   src_i,
    input  logic [VEC_W-1:0]   inact_i,
    output logic [VEC_W-1:0]   res_o,
    output logic               valid_o,
    output logic               err_o
);
    logic [VEC_W-1:0] shifted;
    logic [VEC_W-1:0] merged;
    logic             legal;

    shim_vec_shift #(.VEC_W(VEC_W), .AW(IMM_W)) u_shift (
        .src  (src_i),
        .sz   (lane_sz_i),
        .amt  (imm_i),
        .right(dir_right_i),
        .uns  (unsigned_i),
        .dout (shifted)
    );

    shim_imm_check #(.AW(IMM_W)) u_check (
        .sz   (lane_sz_i),
        .right(dir_right_i),
        .amt  (imm_i),
        .legal(legal)
    );

    shim_pred_merge #(.VEC_W(VEC_W)) u_merge (
        .shifted(shifted),
        .inact  (inact_i),
        .sz     (lane_sz_i),
        .pen    (pred_en_i),
        .pred   (pred_i),
        .dout   (merged)
    );

    // Capture the result on start; otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o   <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= start_i;
            if (start_i) begin
                res_o <= legal ? merged : src_i;
                err_o <= !legal;
            end
        end
    end
endmodule

// File: rtl/shim_checker.sv
// Port-level properties of the immediate shifter, bound to the top module.
module shim_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [1:0]   lane_sz_i,
    input logic         dir_right_i,
    input logic         unsigned_i,
    input logic [5:0]   imm_i,
    input logic         pred_en_i,
    input logic [15:0]  pred_i,
    input logic [127:0] src_i,
    input logic [127:0] inact_i,
    input logic [127:0] res_o,
    input logic         valid_o,
    input logic         err_o
);
    logic [5:0] width_c;
    logic       ok_c;

    // Independent legality view taken from the ports.
    always_comb begin
        width_c = (lane_sz_i == 2'd0) ? 6'd8 : (lane_sz_i == 2'd1) ? 6'd16 : 6'd32;
        if (lane_sz_i == 2'd3)
            ok_c = 1'b0;
        else if (dir_right_i)
            ok_c = (imm_i >= 6'd1) && (imm_i <= width_c);
        else
            ok_c = imm_i < width_c;
    end

    assert_valid_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);

    assert_no_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !valid_o);

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(res_o) && $stable(err_o)));

    assert_error_passthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !ok_c) |=> (err_o && res_o == $past(src_i)));

    assert_lsr_full_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ok_c && dir_right_i && unsigned_i && imm_i == width_c && !pred_en_i)
        |=> (res_o == '0));

    assert_masked_lane0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ok_c && pred_en_i && !pred_i[0]) |=> (res_o[7:0] == $past(inact_i[7:0])));
endmodule

bind simd_imm_shifter shim_checker u_chk (.*);

// File: tb/test_simd_imm_shifter.sv
module test_simd_imm_shifter;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i;
    logic [1:0]   lane_sz_i;
    logic         dir_right_i;
    logic         unsigned_i;
    logic [5:0]   imm_i;
    logic         pred_en_i;
    logic [15:0]  pred_i;
    logic [127:0] src_i;
    logic [127:0] inact_i;
    logic [127:0] res_o;
    logic         valid_o;
    logic         err_o;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [127:0] PAT_A = 128'h80FF_7F01_C3A5_5A3C_8000_0001_FEDC_BA98;
    localparam logic [127:0] PAT_B = 128'h1234_5678_9ABC_DEF0_F00D_CAFE_0BAD_BEEF;
    localparam logic [127:0] INACT = 128'hAAAA_BBBB_CCCC_DDDD_EEEE_FFFF_1111_2222;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_imm_shifter i_simd_imm_shifter (.*);

    // Reference built from the requirements.
    function automatic logic [127:0] model(input logic [1:0] sz, input logic right,
        input logic uns, input logic [5:0] imm, input logic pen, input logic [15:0] pred,
        input logic [127:0] src, input logic [127:0] inact);
        int lw;
        logic ok;
        logic [127:0] r;
        lw = 8 << sz;
        ok = (sz != 2'd3) && (right ? (imm >= 1 && int'(imm) <= lw) : int'(imm) < lw);
        if (!ok) return src;
        r = '0;
        for (int i = 0; i < 128 / lw; i++) begin
            logic [31:0] m, v, w, s;
            logic act;
            int k;
            m = (lw == 32) ? 32'hFFFF_FFFF : ((32'd1 << lw) - 32'd1);
            v = 32'(src >> (i * lw)) & m;
            if (!right) w = (v << imm) & m;
            else if (uns) w = (int'(imm) == lw) ? 32'd0 : (v >> imm);
            else begin
                k = (int'(imm) == lw) ? lw - 1 : int'(imm);
                s = v[lw-1] ? (v | ~m) : v;
                w = 32'($signed(s) >>> k) & m;
            end
            act = pen ? pred[i * lw / 8] : 1'b1;
            if (!act) w = 32'(inact >> (i * lw)) & m;
            r = r | (128'(w) << (i * lw));
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Runs one operation and checks result, error flag and valid strobe.
    task automatic run_op(input string tag, input logic [1:0] sz, input logic right,
        input logic uns, input logic [5:0] imm, input logic pen, input logic [15:0] pred,
        input logic [127:0] src);
        logic [127:0] exp;
        logic exp_err;
        int lw;
        lw = 8 << sz;
        exp_err = (sz == 2'd3) || (right ? (imm == 0 || int'(imm) > lw) : int'(imm) >= lw);
        exp = model(sz, right, uns, imm, pen, pred, src, INACT);
        @(negedge clk);
        lane_sz_i = sz; dir_right_i = right; unsigned_i = uns; imm_i = imm;
        pred_en_i = pen; pred_i = pred; src_i = src; inact_i = INACT; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(res_o == exp, tag, res_o, exp);
        check(err_o == exp_err, {tag, " err"}, 128'(err_o), 128'(exp_err));
        check(valid_o == 1'b1, {tag, " valid R9"}, 128'(valid_o), 128'd1);
    endtask

    task automatic t_reset_R10();
        @(negedge clk);
        check(res_o == '0 && !valid_o && !err_o, "R10 reset state",
              {res_o[125:0], valid_o, err_o}, '0);
    endtask

    task automatic t_lanes_R1();
        for (int sz = 0; sz < 3; sz++)
            run_op("R1 lane width left by 3", 2'(sz), 1'b0, 1'b0, 6'd3, 1'b0, 16'h0, PAT_A);
    endtask

    task automatic t_left_R2();
        run_op("R2 left 8b by 7",   2'd0, 1'b0, 1'b0, 6'd7,  1'b0, 16'h0, PAT_B);
        run_op("R2 left 16b by 15", 2'd1, 1'b0, 1'b0, 6'd15, 1'b0, 16'h0, PAT_A);
        run_op("R2 left 32b by 0",  2'd2, 1'b0, 1'b0, 6'd0,  1'b0, 16'h0, PAT_B);
    endtask

    task automatic t_right_R3();
        run_op("R3 lsr 8b by 1",   2'd0, 1'b1, 1'b1, 6'd1,  1'b0, 16'h0, PAT_A);
        run_op("R3 asr 8b by 4",   2'd0, 1'b1, 1'b0, 6'd4,  1'b0, 16'h0, PAT_A);
        run_op("R3 asr 16b by 10", 2'd1, 1'b1, 1'b0, 6'd10, 1'b0, 16'h0, PAT_A);
        run_op("R3 lsr 32b by 21", 2'd2, 1'b1, 1'b1, 6'd21, 1'b0, 16'h0, PAT_B);
    endtask

    task automatic t_full_lsr_R4();
        for (int sz = 0; sz < 3; sz++)
            run_op("R4 lsr by full width", 2'(sz), 1'b1, 1'b1, 6'(8 << sz), 1'b0, 16'h0, PAT_A);
        check(res_o == '0, "R4 full-width zero", res_o, '0);
    endtask

    task automatic t_full_asr_R5();
        for (int sz = 0; sz < 3; sz++)
            run_op("R5 asr by full width", 2'(sz), 1'b1, 1'b0, 6'(8 << sz), 1'b0, 16'h0, PAT_A);
        // 32-bit lanes of PAT_A: signs 1,1,1,1 -> all ones
        check(res_o == {128{1'b1}}, "R5 sign fill", res_o, {128{1'b1}});
    endtask

    task automatic t_pred_R6();
        logic [127:0] first;
        run_op("R6 pred 8b",  2'd0, 1'b0, 1'b0, 6'd2, 1'b1, 16'hA5C3, PAT_A);
        run_op("R6 pred 32b", 2'd2, 1'b1, 1'b0, 6'd5, 1'b1, 16'h0101, PAT_B);
        run_op("R6 pred 16b", 2'd1, 1'b1, 1'b1, 6'd3, 1'b1, 16'h1411, PAT_B);
        first = res_o;
        // odd predicate bits must not matter for 16-bit lanes
        run_op("R6 pred 16b upper bits", 2'd1, 1'b1, 1'b1, 6'd3, 1'b1, 16'hBEBB, PAT_B);
        check(res_o == first, "R6 ignored predicate bits", res_o, first);
    endtask

    task automatic t_nopred_R7();
        logic [127:0] exp;
        exp = model(2'd1, 1'b0, 1'b0, 6'd4, 1'b1, 16'hFFFF, PAT_A, INACT);
        run_op("R7 pred off", 2'd1, 1'b0, 1'b0, 6'd4, 1'b0, 16'h0000, PAT_A);
        check(res_o == exp, "R7 all lanes shifted", res_o, exp);
    endtask

    task automatic t_illegal_R8();
        run_op("R8 left 8b by 8",    2'd0, 1'b0, 1'b0, 6'd8,  1'b1, 16'h0, PAT_A);
        run_op("R8 right by 0",      2'd1, 1'b1, 1'b1, 6'd0,  1'b0, 16'h0, PAT_B);
        run_op("R8 right 16b by 17", 2'd1, 1'b1, 1'b0, 6'd17, 1'b0, 16'h0, PAT_A);
        run_op("R8 reserved size",   2'd3, 1'b0, 1'b0, 6'd1,  1'b0, 16'h0, PAT_B);
        run_op("R8 legal clears err", 2'd2, 1'b1, 1'b0, 6'd32, 1'b0, 16'h0, PAT_B);
    endtask

    task automatic t_hold_R9();
        logic [127:0] kept;
        run_op("R9 setup", 2'd0, 1'b0, 1'b0, 6'd1, 1'b0, 16'h0, PAT_B);
        kept = res_o;
        src_i = PAT_A; imm_i = 6'd9; lane_sz_i = 2'd3;
        repeat (3) @(negedge clk);
        check(res_o == kept && !valid_o && !err_o, "R9 hold while idle", res_o, kept);
    endtask

    task automatic t_reset_mid_R10();
        run_op("R10 setup", 2'd0, 1'b0, 1'b0, 6'd9, 1'b0, 16'h0, PAT_A);
        rst_n = 1'b0;
        @(negedge clk);
        check(res_o == '0 && !valid_o && !err_o, "R10 reset clears", res_o, '0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; lane_sz_i = 2'd0; dir_right_i = 1'b0;
        unsigned_i = 1'b0; imm_i = '0; pred_en_i = 1'b0; pred_i = '0;
        src_i = '0; inact_i = '0;
        repeat (2) @(posedge clk);
        t_reset_R10();
        rst_n = 1'b1;
        t_lanes_R1();
        t_left_R2();
        t_right_R3();
        t_full_lsr_R4();
        t_full_asr_R5();
        t_pred_R6();
        t_nopred_R7();
        t_illegal_R8();
        t_hold_R9();
        t_reset_mid_R10();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule